// File: doc/BRIEF.md
# Power Mode Sequencer with Qualified Wake

This block places a small microcontroller in one of three operating modes: normal, idle or power-down. Software enters a low-power mode by writing a control word. The block then decides which clocks run. In idle, only the core clock stops, and the peripherals keep working. In power-down, the oscillator enable drops, the peripheral clock enable drops and the DAC driver turns off so its output floats. The port outputs are outside this block and keep their levels.

Leaving a sleep mode works differently for each depth. In idle, any pending interrupt that the interrupt controller has already qualified brings the core back. In power-down, the interval timer always wakes the chip. The serial and external interrupt lines wake it only if their own wake-enable bits are set. After a power-down wake, the oscillator restarts first. Core and peripheral clocks return only after a programmable settle count. A one-cycle wake pulse and a source code then tell the core which interrupt caused the wake.

A synchronous reset returns the block to normal mode and to its default settings from any mode. After reset is released, a fixed startup count holds the core in reset before it may run.

Top module: `pmc_top`

## Requirements
- R1: After `rst_n` is released, `core_rst_n` stays low for exactly `STARTUP_CYCLES` rising clock edges and then goes high. Control writes made while it is low are ignored, so `mode` stays 0.
- R2: Normal mode has these outputs: `mode` = 0, core clock running, `periph_clk_en` = 1, `osc_en` = 1, `dac_oe` = 1. This is also the state right after reset.
- R3: A control write in normal mode takes effect at the clock edge that captures it. The control word has these fields:
  - Bit 1 requests power-down (`mode` = 2).
  - Bit 0 requests idle (`mode` = 1). If both bits are set, bit 1 wins.
  - Bit 2 is the serial wake enable.
  - Bit 3 is the external wake enable.
  - Bits [3+SETTLE_W:4] hold the settle count.
- R4: Idle mode has these outputs: `mode` = 1, core clock stopped, `periph_clk_en` = 1, `osc_en` = 1, `dac_oe` = 1.
- R5: Idle ends on `int_pend` alone. The third rising edge after the line is raised returns `mode` to 0, with `wake_pulse` = 1 for one cycle and `wake_src` = 0. The timer, serial and external lines by themselves leave idle unchanged.
- R6: Power-down mode has these outputs: `mode` = 2, `osc_en` = 0, `periph_clk_en` = 0, `dac_oe` = 0, core clock stopped.
- R7: The timer line always ends power-down. `osc_en` rises at the third rising edge after the line is raised, and the wake reports `wake_src` = 1.
- R8: The serial line ends power-down only when its wake enable is set, and reports `wake_src` = 2. The external line does the same with its own enable and reports `wake_src` = 3. A disabled line, or `int_pend`, leaves power-down unchanged with `osc_en` = 0.
- R9: After `osc_en` rises on a power-down wake, the clocks return exactly settle+1 edges later. At that edge `periph_clk_en`, `dac_oe` and `wake_pulse` rise, and `mode` becomes 0.
- R10: When several enabled wake lines are active in the same cycle, `wake_src` reports the highest-priority one. The order is timer, then serial, then external.
- R11: Pulling `rst_n` low in any mode returns the block to normal mode with `osc_en` = 1 and `dac_oe` = 1, and the R1 startup count begins again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on block clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 4+SETTLE_W | Control word: idle, power-down, serial enable, external enable, settle count |
| int_pend | input | 1 | Any enabled interrupt pending (from interrupt controller) |
| tic_irq | input | 1 | Interval timer interrupt |
| ser_irq | input | 1 | Serial interface interrupt |
| ext_irq | input | 1 | External interrupt line |
| core_clk | output | 1 | Gated core clock |
| core_rst_n | output | 1 | Core reset, released after startup count |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| dac_oe | output | 1 | DAC driver enable (0 = high impedance) |
| wake_pulse | output | 1 | One-cycle pulse when the core clock resumes after a wake |
| wake_src | output | 2 | Wake cause: 0 idle interrupt, 1 timer, 2 serial, 3 external |
| mode | output | 2 | Current mode: 0 normal, 1 idle, 2 power-down |

## Verification
The hardest situation to reach from the ports is a power-down that must *not* end. A disabled serial or external line, or a pending interrupt that only counts in idle, has to be held active for many cycles while the oscillator stays off. Afterwards the timer must recover the chip cleanly, without stale synchronizer state waking the next sleep early. The stimulus mixes directed cases with random combinations of enables, active lines and settle counts, so masked wakes and several lines at once both occur often. A reset is also applied while the chip is in power-down.

// File: rtl/pmc_pkg.sv
// Shared types for the power mode sequencer.
// Assumes: two-bit state encoding and two-bit wake source codes.
package pmc_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_IDLE   = 2'd1,
        ST_PD     = 2'd2,
        ST_SETTLE = 2'd3
    } pm_state_t;

    localparam logic [1:0] MODE_NORMAL = 2'd0;
    localparam logic [1:0] MODE_IDLE   = 2'd1;
    localparam logic [1:0] MODE_PD     = 2'd2;

    localparam logic [1:0] SRC_IDLE_IRQ = 2'd0;
    localparam logic [1:0] SRC_TIMER    = 2'd1;
    localparam logic [1:0] SRC_SERIAL   = 2'd2;
    localparam logic [1:0] SRC_EXT      = 2'd3;
endpackage

// File: rtl/pmc_sync.sv
// Two-stage synchronizer for a vector of independent level inputs.
// Assumes: each bit is a slow level, so the bits need not stay coherent with each other.
module pmc_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [1:0] stg;
        // Shift the raw level through two flops.
        always_ff @(posedge clk) begin
            if (!rst_n) stg <= 2'b00;
            else        stg <= {stg[0], d[g]};
        end
        assign q[g] = stg[1];
    end
endmodule

// File: rtl/pmc_startup.sv
// Startup hold counter: done goes high LIMIT edges after reset release.
// Assumes: LIMIT >= 1, and the clock is running during startup.
module pmc_startup #(
    parameter int unsigned LIMIT = 2048000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    // Count edges until the limit, then latch done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            if (cnt == CW'(LIMIT - 1)) done <= 1'b1;
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pmc_wake_qual.sv
// Wake qualification: decides which synchronized lines may end each sleep depth.
// Assumes: inputs are already synchronized; the priority is timer > serial > external.
module pmc_wake_qual
    import pmc_pkg::*;
(
    input  logic       int_s,
    input  logic       tic_s,
    input  logic       ser_s,
    input  logic       ext_s,
    input  logic       ser_en,
    input  logic       ext_en,
    output logic       idle_wake,
    output logic       pd_wake,
    output logic [1:0] pd_src
);
    logic ser_ok, ext_ok;

    assign ser_ok    = ser_s & ser_en;
    assign ext_ok    = ext_s & ext_en;
    assign idle_wake = int_s;
    assign pd_wake   = tic_s | ser_ok | ext_ok;

    // Encode the highest-priority qualified source.
    always_comb begin
        if (tic_s)       pd_src = SRC_TIMER;
        else if (ser_ok) pd_src = SRC_SERIAL;
        else             pd_src = SRC_EXT;
    end
endmodule

// File: rtl/pmc_mode_fsm.sv
// Mode state machine with the control register, the settle counter and the wake report.
// Assumes: writes come only from a running core; writes outside normal mode
// or before startup completes are dropped.
module pmc_mode_fsm
    import pmc_pkg::*;
#(
    parameter int                SETTLE_W   = 6,
    parameter logic [SETTLE_W-1:0] SETTLE_RST = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_ok,
    input  logic                  ctl_we,
    input  logic [4+SETTLE_W-1:0] ctl_wdata,
    input  logic                  idle_wake,
    input  logic                  pd_wake,
    input  logic [1:0]            pd_src,
    output pm_state_t             state,
    output logic                  ser_en,
    output logic                  ext_en,
    output logic                  wake_pulse,
    output logic [1:0]            wake_src
);
    pm_state_t         nxt;
    logic              wr_ok;
    logic [SETTLE_W-1:0] settle_val;
    logic [SETTLE_W-1:0] cnt;

    assign wr_ok = ctl_we & run_ok & (state == ST_RUN);

    // Next-mode decision; power-down outranks idle in the same write.
    always_comb begin
        nxt = state;
        case (state)
            ST_RUN:    if (wr_ok) begin
                           if (ctl_wdata[1])      nxt = ST_PD;
                           else if (ctl_wdata[0]) nxt = ST_IDLE;
                       end
            ST_IDLE:   if (idle_wake) nxt = ST_RUN;
            ST_PD:     if (pd_wake)   nxt = ST_SETTLE;
            ST_SETTLE: if (cnt == '0) nxt = ST_RUN;
            default:   nxt = ST_RUN;
        endcase
    end

    // State, control fields, settle counter and wake report registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_RUN;
            ser_en     <= 1'b0;
            ext_en     <= 1'b0;
            settle_val <= SETTLE_RST;
            cnt        <= '0;
            wake_pulse <= 1'b0;
            wake_src   <= SRC_IDLE_IRQ;
        end else begin
            state      <= nxt;
            wake_pulse <= (nxt == ST_RUN) && (state != ST_RUN);
            if (wr_ok) begin
                ser_en     <= ctl_wdata[2];
                ext_en     <= ctl_wdata[3];
                settle_val <= ctl_wdata[4 +: SETTLE_W];
            end
            if (state == ST_PD && pd_wake) begin
                cnt      <= settle_val;
                wake_src <= pd_src;
            end else if (state == ST_SETTLE && cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
            if (state == ST_IDLE && idle_wake) wake_src <= SRC_IDLE_IRQ;
        end
    end
endmodule

// File: rtl/pmc_top.sv
// Power mode sequencer top: joins synchronizers, startup hold, wake qualification,
// mode FSM and the core clock gate.
// Assumes: clk runs at all times (it keeps running when osc_en is low), and rst_n is
// synchronous active-low.
module pmc_top
    import pmc_pkg::*;
#(
    parameter int unsigned         STARTUP_CYCLES = 2048000,
    parameter int                  SETTLE_W       = 6,
    parameter logic [SETTLE_W-1:0] SETTLE_RST     = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctl_we,
    input  logic [4+SETTLE_W-1:0] ctl_wdata,
    input  logic                  int_pend,
    input  logic                  tic_irq,
    input  logic                  ser_irq,
    input  logic                  ext_irq,
    output logic                  core_clk,
    output logic                  core_rst_n,
    output logic                  periph_clk_en,
    output logic                  osc_en,
    output logic                  dac_oe,
    output logic                  wake_pulse,
    output logic [1:0]            wake_src,
    output logic [1:0]            mode
);
    localparam int NSRC = 4;

    logic [NSRC-1:0] raw_lines, sync_lines;
    logic            run_ok, idle_wake, pd_wake, ser_en, ext_en, gate_lo;
    logic [1:0]      pd_src;
    pm_state_t       state;

    assign raw_lines = {ext_irq, ser_irq, tic_irq, int_pend};

    pmc_sync #(.W(NSRC)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_lines), .q(sync_lines)
    );

    pmc_startup #(.LIMIT(STARTUP_CYCLES)) u_start (
        .clk(clk), .rst_n(rst_n), .done(run_ok)
    );

    pmc_wake_qual u_qual (
        .int_s(sync_lines[0]), .tic_s(sync_lines[1]),
        .ser_s(sync_lines[2]), .ext_s(sync_lines[3]),
        .ser_en(ser_en), .ext_en(ext_en),
        .idle_wake(idle_wake), .pd_wake(pd_wake), .pd_src(pd_src)
    );

    pmc_mode_fsm #(.SETTLE_W(SETTLE_W), .SETTLE_RST(SETTLE_RST)) u_fsm (
        .clk(clk), .rst_n(rst_n), .run_ok(run_ok),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .idle_wake(idle_wake), .pd_wake(pd_wake), .pd_src(pd_src),
        .state(state), .ser_en(ser_en), .ext_en(ext_en),
        .wake_pulse(wake_pulse), .wake_src(wake_src)
    );

    // Capture the core gate on the falling edge so the gated clock has no glitch.
    always_ff @(negedge clk) begin
        if (!rst_n) gate_lo <= 1'b1;
        else        gate_lo <= (state == ST_RUN);
    end

    assign core_clk      = clk & gate_lo;
    assign core_rst_n    = run_ok;
    assign periph_clk_en = (state == ST_RUN) || (state == ST_IDLE);
    assign osc_en        = (state != ST_PD);
    assign dac_oe        = (state == ST_RUN) || (state == ST_IDLE);

    // Map internal state to the reported mode code.
    always_comb begin
        case (state)
            ST_RUN:  mode = MODE_NORMAL;
            ST_IDLE: mode = MODE_IDLE;
            default: mode = MODE_PD;
        endcase
    end
endmodule

// File: rtl/pmc_chk.sv
// Property checker for pmc_top, attached through bind.
// Assumes: sees only top-level ports.
module pmc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       core_rst_n,
    input logic       periph_clk_en,
    input logic       osc_en,
    input logic       dac_oe,
    input logic       wake_pulse,
    input logic [1:0] mode
);
    AST_STARTUP_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        !core_rst_n |-> mode == 2'd0);                                        // R1
    AST_IDLE_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'd1 |-> (periph_clk_en && osc_en && dac_oe));                 // R4
    AST_PD_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && !osc_en) |-> (!periph_clk_en && !dac_oe));            // R6
    AST_OSC_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(periph_clk_en) |-> $past(osc_en));                               // R9
    AST_WAKE_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> (mode == 2'd0 && periph_clk_en && dac_oe));             // R9
    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);                                           // R5
endmodule

bind pmc_top pmc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .core_rst_n(core_rst_n),
    .periph_clk_en(periph_clk_en), .osc_en(osc_en), .dac_oe(dac_oe),
    .wake_pulse(wake_pulse), .mode(mode)
);

// File: tb/pmc_top_tb_top.sv
// Bench for pmc_top: directed corners plus seeded random sleep/wake scenarios.
module pmc_top_tb_top;
    localparam int SW = 6;
    localparam int ST = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_we = 1'b0;
    logic [4+SW-1:0] ctl_wdata = '0;
    logic          int_pend = 0, tic_irq = 0, ser_irq = 0, ext_irq = 0;
    logic          core_clk, core_rst_n, periph_clk_en, osc_en, dac_oe, wake_pulse;
    logic [1:0]    wake_src, mode;

    int nchk = 0;
    int nfail = 0;
    int cclk = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    pmc_top #(.STARTUP_CYCLES(ST), .SETTLE_W(SW), .SETTLE_RST(6'd8)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .int_pend(int_pend), .tic_irq(tic_irq), .ser_irq(ser_irq), .ext_irq(ext_irq),
        .core_clk(core_clk), .core_rst_n(core_rst_n), .periph_clk_en(periph_clk_en),
        .osc_en(osc_en), .dac_oe(dac_oe), .wake_pulse(wake_pulse),
        .wake_src(wake_src), .mode(mode)
    );

    always @(posedge core_clk) cclk++;

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_src(bit t, bit s, bit e, bit sen, bit een);
        if (t) return 1;
        if (s && sen) return 2;
        if (e && een) return 3;
        return -1;
    endfunction

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(logic [4+SW-1:0] d);
        ctl_we = 1'b1;
        ctl_wdata = d;
        cyc(1);
        ctl_we = 1'b0;
    endtask

    task automatic clear_lines();
        int_pend = 0; tic_irq = 0; ser_irq = 0; ext_irq = 0;
        cyc(3);
    endtask

    // Lines were driven at the current falling edge; follow the power-down wake.
    task automatic follow_pd_wake(int st, int src);
        int k;
        cyc(2);
        chk("R7 osc still off two edges after line", int'(osc_en), 0);
        cyc(1);
        chk("R7 osc on third edge", int'(osc_en), 1);
        chk("R9 clocks still gated while settling", int'(periph_clk_en), 0);
        k = 0;
        while (!periph_clk_en && k < 100) begin
            cyc(1);
            k++;
        end
        chk("R9 settle length", k, st + 1);
        chk("R9 wake pulse", int'(wake_pulse), 1);
        chk("R9 dac back on", int'(dac_oe), 1);
        chk("R9 mode normal", int'(mode), 0);
        chk("R10 wake source", int'(wake_src), src);
        cyc(1);
        chk("R9 wake pulse single", int'(wake_pulse), 0);
    endtask

    task automatic do_pd(bit sen, bit een, int st, bit t, bit s, bit e, bit ip);
        int src, c0;
        wr({SW'(st), een, sen, 2'b10});
        chk("R6 mode pd", int'(mode), 2);
        chk("R6 osc off", int'(osc_en), 0);
        chk("R6 periph off", int'(periph_clk_en), 0);
        chk("R6 dac hiz", int'(dac_oe), 0);
        c0 = cclk;
        cyc(3);
        chk("R6 core clock stopped", cclk - c0, 0);
        tic_irq = t; ser_irq = s; ext_irq = e; int_pend = ip;
        src = exp_src(t, s, e, sen, een);
        if (src > 0) begin
            follow_pd_wake(st, src);
            clear_lines();
        end else begin
            cyc(12);
            chk("R8 masked line keeps pd", int'(mode), 2);
            chk("R8 masked line keeps osc off", int'(osc_en), 0);
            clear_lines();
            tic_irq = 1;
            follow_pd_wake(st, 1);
            clear_lines();
        end
    endtask

    task automatic do_idle(bit t, bit s, bit e);
        int c0;
        wr({6'd8, 2'b11, 2'b01});
        chk("R4 mode idle", int'(mode), 1);
        chk("R4 periph on", int'(periph_clk_en), 1);
        chk("R4 osc on", int'(osc_en), 1);
        chk("R4 dac on", int'(dac_oe), 1);
        cyc(1);
        c0 = cclk;
        cyc(4);
        chk("R4 core clock stopped", cclk - c0, 0);
        tic_irq = t; ser_irq = s; ext_irq = e;
        cyc(6);
        chk("R5 other lines ignored in idle", int'(mode), 1);
        int_pend = 1;
        cyc(2);
        chk("R5 idle before third edge", int'(mode), 1);
        cyc(1);
        chk("R5 mode normal", int'(mode), 0);
        chk("R5 wake pulse", int'(wake_pulse), 1);
        chk("R5 wake source", int'(wake_src), 0);
        clear_lines();
        chk("R5 pulse gone", int'(wake_pulse), 0);
    endtask

    task automatic reset_and_start(bit try_write);
        int k, c0;
        rst_n = 0;
        cyc(4);
        chk("R11 mode normal in reset", int'(mode), 0);
        chk("R11 osc on in reset", int'(osc_en), 1);
        chk("R11 dac on in reset", int'(dac_oe), 1);
        rst_n = 1;
        chk("R1 core reset held", int'(core_rst_n), 0);
        chk("R2 periph on", int'(periph_clk_en), 1);
        k = 0;
        while (!core_rst_n && k < ST + 20) begin
            if (try_write && k == 5) begin
                ctl_we = 1; ctl_wdata = {6'd2, 2'b00, 2'b10};
            end else begin
                ctl_we = 0;
            end
            cyc(1);
            k++;
            if (try_write && k == 6) chk("R1 write ignored in startup", int'(mode), 0);
        end
        ctl_we = 0;
        chk("R1 startup length", k, ST);
        c0 = cclk;
        cyc(5);
        chk("R2 core clock runs", cclk - c0, 5);
        chk("R2 mode normal", int'(mode), 0);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual 1 expected 0");
            report();
        end
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        reset_and_start(1);

        // R3: both request bits set, power-down wins; timer wakes (R7)
        wr({6'd8, 2'b00, 2'b11});
        chk("R3 pd wins over idle", int'(mode), 2);
        tic_irq = 1;
        follow_pd_wake(8, 1);
        clear_lines();

        do_idle(1, 1, 1);
        do_pd(0, 1, 3, 0, 1, 0, 1);     // R8 serial masked, int_pend ignored
        do_pd(0, 1, 0, 0, 0, 1, 0);     // R8 external enabled, settle 0
        do_pd(1, 0, 5, 0, 1, 0, 0);     // R8 serial enabled
        do_pd(1, 1, 2, 1, 1, 1, 0);     // R10 timer first
        do_pd(1, 1, 4, 0, 1, 1, 0);     // R10 serial over external
        do_pd(0, 0, 1, 0, 1, 1, 1);     // R8 both masked

        for (int i = 0; i < 40; i++) begin
            if ($urandom % 4 == 0)
                do_idle(1'($urandom), 1'($urandom), 1'($urandom));
            else
                do_pd(1'($urandom), 1'($urandom), int'($urandom % 16),
                      1'($urandom % 3 == 0), 1'($urandom), 1'($urandom), 1'($urandom));
        end

        // R11: reset while in power-down
        wr({6'd3, 2'b01, 2'b10});
        chk("R11 in pd before reset", int'(osc_en), 0);
        reset_and_start(0);
        do_pd(1, 0, 2, 0, 1, 0, 0);

        done = 1;
        report();
    end
endmodule